// File: doc/BRIEF.md
# Card Interrupt Flag and Line Driver

This block turns a PC Card socket's interrupt request into a sticky flag and drives it onto one of the system interrupt lines. Sixteen output positions are provided, numbered by interrupt line. Only ten of them can be driven: lines 3, 4, 5, 7, 9, 10, 11, 12, 14 and 15. Software chooses the drive style of each drivable line separately. In open-drain mode the line is shared and active-low. In push-pull mode the line is a dedicated legacy line and is active-high.

A `lineSel` input names the line the socket uses. While the flag is set, that line is asserted. Software writes a 1 to the flag to clear it, and a new request during that same clock wins over the clear. A small register file holds the two mode registers, the flag, an 8-bit interrupt-line scratch byte and a fixed interrupt-pin value. Reads return data combinationally from `regRdAddr`.

Top module: `irq_route_unit`

## Requirements
- R1: On each clock edge where `cardIrq` is 1, the flag is set. It stays set after `cardIrq` returns to 0. The flag reads as bit 0 at address 2.
- R2: A write to address 2 with data bit 0 equal to 1 clears the flag. A write with bit 0 equal to 0 leaves the flag unchanged.
- R3: When a clear write and `cardIrq`=1 fall on the same edge, the flag ends up set.
- R4: Reset clears both mode registers, the flag and the scratch byte. After reset, no output is enabled and no output is high.
- R5: Address 0 holds the mode bits for lines 3, 4, 5 and 7 in bits 0 to 3. Address 1 holds the mode bits for lines 9, 10, 11, 12, 14 and 15 in bits 0 to 5. The other bits of both registers read as 0 and ignore writes.
- R6: A line whose mode bit is 0 is open-drain. When it is asserted, `irqOe` is 1 and `irqOut` is 0. When it is not asserted, `irqOe` is 0 and `irqOut` is 0.
- R7: A line whose mode bit is 1 is push-pull. `irqOe` is always 1, and `irqOut` equals the line's asserted state.
- R8: A line is asserted only when the flag is set and `lineSel` equals its number. A `lineSel` value of 0, 1, 2, 6, 8 or 13 asserts no line. Output positions 0, 1, 2, 6, 8 and 13 always stay 0.
- R9: Address 4 always reads 1, and writes to it are ignored. Address 3 is an 8-bit read/write scratch byte, and writing it does not change any output.
- R10: Addresses 5 to 7 read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cardIrq | input | 1 | Card interrupt request, level |
| lineSel | input | 4 | Interrupt line number the socket uses |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register write address |
| regWrData | input | 8 | Register write data |
| regRdAddr | input | 3 | Register read address |
| regRdData | output | 8 | Register read data (combinational) |
| irqOe | output | 16 | Output enable, one bit per line number |
| irqOut | output | 16 | Output data, one bit per line number |

## Verification
The bench builds the block with its default 4-bit line select, which makes all sixteen line numbers reachable. That includes the six undrivable ones, so every select value can be swept against both mode settings. The 8-bit register width lets the bench write the reserved mode bits and check that they read back as 0. A behavioural model compares all three outputs on every cycle. Meanwhile the read address cycles through all eight addresses, so register contents are observed continuously, including across the same-edge clear-versus-request case and a reset in mid-run.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int REG_W       = 8;
  localparam int ADDR_W      = 3;
  localparam int MODE_A_BITS = 4;
  localparam int MODE_B_BITS = 6;

  localparam logic [ADDR_W-1:0] ADDR_MODE_A = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_MODE_B = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG   = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_LINE   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_PIN    = 3'd4;

  localparam logic [REG_W-1:0] PIN_VALUE = 8'd1;

  // Strobes from control to datapath
  typedef struct packed {
    logic             wrModeA;
    logic             wrModeB;
    logic             clrFlag;
    logic             wrLine;
    logic [REG_W-1:0] wrData;
    logic             rdModeA;
    logic             rdModeB;
    logic             rdFlag;
    logic             rdLine;
    logic             rdPin;
  } strobe_t;

  // Mode bit location for a line number: {valid, bank B, bit[2:0]}
  function automatic logic [4:0] lineMap(input int n);
    case (n)
      3:       return 5'b10_000;
      4:       return 5'b10_001;
      5:       return 5'b10_010;
      7:       return 5'b10_011;
      9:       return 5'b11_000;
      10:      return 5'b11_001;
      11:      return 5'b11_010;
      12:      return 5'b11_011;
      14:      return 5'b11_100;
      15:      return 5'b11_101;
      default: return 5'b00_000;
    endcase
  endfunction
endpackage

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
  import irq_route_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [ADDR_W-1:0] regRdAddr,
  output strobe_t           stb
);
  always_comb begin
    stb         = '0;
    stb.wrData  = regWrData;
    if (regWrEn) begin
      unique case (regAddr)
        ADDR_MODE_A: stb.wrModeA = 1'b1;
        ADDR_MODE_B: stb.wrModeB = 1'b1;
        ADDR_FLAG:   stb.clrFlag = regWrData[0];
        ADDR_LINE:   stb.wrLine  = 1'b1;
        default:     ;
      endcase
    end
    unique case (regRdAddr)
      ADDR_MODE_A: stb.rdModeA = 1'b1;
      ADDR_MODE_B: stb.rdModeB = 1'b1;
      ADDR_FLAG:   stb.rdFlag  = 1'b1;
      ADDR_LINE:   stb.rdLine  = 1'b1;
      ADDR_PIN:    stb.rdPin   = 1'b1;
      default:     ;
    endcase
  end
endmodule

// File: rtl/irq_route_dp.sv
module irq_route_dp
  import irq_route_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int NUM_LINES = 1 << SEL_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cardIrq,
  input  logic [SEL_W-1:0]     lineSel,
  input  strobe_t              stb,
  output logic [REG_W-1:0]     regRdData,
  output logic                 cardFlag,
  output logic [NUM_LINES-1:0] irqOe,
  output logic [NUM_LINES-1:0] irqOut
);
  logic [MODE_A_BITS-1:0] modeA;
  logic [MODE_B_BITS-1:0] modeB;
  logic [REG_W-1:0]       lineByte;
  logic                   flagQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeA    <= '0;
      modeB    <= '0;
      lineByte <= '0;
      flagQ    <= 1'b0;
    end else begin
      if (stb.wrModeA) modeA    <= stb.wrData[MODE_A_BITS-1:0];
      if (stb.wrModeB) modeB    <= stb.wrData[MODE_B_BITS-1:0];
      if (stb.wrLine)  lineByte <= stb.wrData;
      // request wins over a same-edge clear
      if (cardIrq)          flagQ <= 1'b1;
      else if (stb.clrFlag) flagQ <= 1'b0;
    end
  end

  assign cardFlag = flagQ;

  always_comb begin
    regRdData = '0;
    if (stb.rdModeA) regRdData[MODE_A_BITS-1:0] = modeA;
    if (stb.rdModeB) regRdData[MODE_B_BITS-1:0] = modeB;
    if (stb.rdFlag)  regRdData[0] = flagQ;
    if (stb.rdLine)  regRdData = lineByte;
    if (stb.rdPin)   regRdData = PIN_VALUE;
  end

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    localparam logic [4:0] MAP = lineMap(n);
    if (MAP[4]) begin : g_drv
      logic pushPull;
      logic active;
      if (MAP[3]) begin : g_b
        assign pushPull = modeB[MAP[2:0]];
      end else begin : g_a
        assign pushPull = modeA[MAP[2:0]];
      end
      assign active    = flagQ && (lineSel == SEL_W'(n));
      assign irqOe[n]  = pushPull | active;
      assign irqOut[n] = pushPull & active;
    end else begin : g_none
      assign irqOe[n]  = 1'b0;
      assign irqOut[n] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_route_unit.sv
module irq_route_unit
  import irq_route_pkg::*;
#(
  parameter int SEL_W = 4,
  localparam int NUM_LINES = 1 << SEL_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cardIrq,
  input  logic [SEL_W-1:0]     lineSel,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWrData,
  input  logic [ADDR_W-1:0]    regRdAddr,
  output logic [REG_W-1:0]     regRdData,
  output logic [NUM_LINES-1:0] irqOe,
  output logic [NUM_LINES-1:0] irqOut
);
  strobe_t stb;
  logic    cardFlag;

  irq_route_ctrl u_ctrl (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .regRdAddr (regRdAddr),
    .stb       (stb)
  );

  irq_route_dp #(.SEL_W(SEL_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .cardIrq   (cardIrq),
    .lineSel   (lineSel),
    .stb       (stb),
    .regRdData (regRdData),
    .cardFlag  (cardFlag),
    .irqOe     (irqOe),
    .irqOut    (irqOut)
  );
endmodule

// File: rtl/irq_route_chk.sv
module irq_route_chk
  import irq_route_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              cardIrq,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0]  regWrData,
  input logic [ADDR_W-1:0] regRdAddr,
  input logic [REG_W-1:0]  regRdData,
  input logic [15:0]       irqOe,
  input logic [15:0]       irqOut,
  input logic              cardFlag
);
  localparam logic [15:0] UNDRIVEN = 16'h2147;

  logic clrWr;
  assign clrWr = regWrEn && (regAddr == ADDR_FLAG) && regWrData[0];

  assert_flag_sets_R1: assert property (@(posedge clk) disable iff (!rstN)
    cardIrq |=> cardFlag);

  assert_clear_works_R2: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !cardIrq) |=> !cardFlag);

  assert_zero_write_keeps_R2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADDR_FLAG && !regWrData[0] && cardFlag) |=> cardFlag);

  assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && cardIrq) |=> cardFlag);

  assert_no_high_without_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & ~irqOe) == 16'h0);

  assert_idle_outputs_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !cardFlag |-> irqOut == 16'h0);

  assert_single_line_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqOut));

  assert_undriven_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    ((irqOe | irqOut) & UNDRIVEN) == 16'h0);

  assert_pin_reads_one_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdAddr == ADDR_PIN) |-> regRdData == PIN_VALUE);

  assert_hole_reads_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    (regRdAddr > ADDR_PIN) |-> regRdData == '0);
endmodule

bind irq_route_unit irq_route_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cardIrq   (cardIrq),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .regRdAddr (regRdAddr),
  .regRdData (regRdData),
  .irqOe     (irqOe),
  .irqOut    (irqOut),
  .cardFlag  (cardFlag)
);

// File: tb/irq_route_unit_tb.sv
module irq_route_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cardIrq = 1'b0;
  logic [3:0]  lineSel = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [2:0]  regRdAddr = '0;
  logic [7:0]  regRdData;
  logic [15:0] irqOe;
  logic [15:0] irqOut;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string tag = "R4";

  // behavioural model state
  int mA = 0, mB = 0, mFlag = 0, mLine = 0;
  int drivable[10] = '{3, 4, 5, 7, 9, 10, 11, 12, 14, 15};

  irq_route_unit u_dut (
    .clk(clk), .rstN(rstN), .cardIrq(cardIrq), .lineSel(lineSel),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdAddr(regRdAddr), .regRdData(regRdData),
    .irqOe(irqOe), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rstN) begin
      mA = 0; mB = 0; mFlag = 0; mLine = 0;
    end else begin
      if (regWrEn) begin
        case (regAddr)
          3'd0: mA = regWrData & 8'h0F;
          3'd1: mB = regWrData & 8'h3F;
          3'd2: if (regWrData[0] && !cardIrq) mFlag = 0;
          3'd3: mLine = regWrData;
          default: ;
        endcase
      end
      if (cardIrq) mFlag = 1;
    end
  end

  function automatic int modeOf(int line);
    for (int i = 0; i < 10; i++)
      if (drivable[i] == line) return (i < 4) ? ((mA >> i) & 1) : ((mB >> (i - 4)) & 1);
    return -1;
  endfunction

  task automatic compare();
    logic [15:0] eOe, eOut;
    logic [7:0]  eRd;
    eOe = '0; eOut = '0;
    for (int n = 0; n < 16; n++) begin
      int md;
      bit act;
      md  = modeOf(n);
      act = (mFlag == 1) && (lineSel == n);
      if (md == 1) begin eOe[n] = 1'b1; eOut[n] = act; end
      else if (md == 0) begin eOe[n] = act; end
    end
    case (regRdAddr)
      3'd0: eRd = 8'(mA);
      3'd1: eRd = 8'(mB);
      3'd2: eRd = 8'(mFlag);
      3'd3: eRd = 8'(mLine);
      3'd4: eRd = 8'd1;
      default: eRd = 8'd0;
    endcase
    checks++;
    if (irqOe !== eOe || irqOut !== eOut || regRdData !== eRd) begin
      fails++;
      $display("FAIL %s cycle %0d: oe=%h out=%h rd=%h expected oe=%h out=%h rd=%h",
               tag, cycles, irqOe, irqOut, regRdData, eOe, eOut, eRd);
    end
  endtask

  task automatic step(input string t, input bit irq, input int sel,
                      input bit we, input int addr, input int data);
    @(negedge clk);
    compare();
    tag       = t;
    cardIrq   = irq;
    lineSel   = 4'(sel);
    regWrEn   = we;
    regAddr   = 3'(addr);
    regWrData = 8'(data);
    regRdAddr = 3'(cycles);
  endtask

  task automatic sweep(input string t);
    for (int s = 0; s < 16; s++) step(t, 0, s, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      fails++;
      $display("FAIL watchdog expired, actual cycles %0d expected below %0d", cycles, WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R4: reset state
    for (int i = 0; i < 4; i++) step("R4", 0, 3, 0, 0, 0);
    rstN = 1'b1;
    for (int i = 0; i < 8; i++) step("R4", 0, 3, 0, 0, 0);
    // R1: sticky flag, open-drain default R6, select sweep R8
    step("R1", 1, 3, 0, 0, 0);
    for (int i = 0; i < 4; i++) step("R1", 0, 3, 0, 0, 0);
    sweep("R6");
    sweep("R8");
    // R2: write 0 keeps, write 1 clears
    step("R2", 0, 5, 1, 2, 8'hFE);
    for (int i = 0; i < 4; i++) step("R2", 0, 5, 0, 0, 0);
    step("R2", 0, 5, 1, 2, 1);
    for (int i = 0; i < 4; i++) step("R2", 0, 5, 0, 0, 0);
    // R5/R7: bank A push-pull, reserved bits written
    step("R5", 0, 4, 1, 0, 8'hFF);
    for (int i = 0; i < 8; i++) step("R5", 0, 4, 0, 0, 0);
    sweep("R7");
    step("R7", 1, 4, 0, 0, 0);
    sweep("R7");
    // R5: bank B pattern, mixed modes
    step("R5", 0, 9, 1, 1, 8'hEA);
    step("R5", 0, 9, 1, 0, 8'hF5);
    for (int i = 0; i < 8; i++) step("R5", 0, 9, 0, 0, 0);
    sweep("R5");
    // R3: clear and request on same edge
    step("R3", 1, 14, 1, 2, 1);
    for (int i = 0; i < 4; i++) step("R3", 0, 14, 0, 0, 0);
    step("R3", 0, 14, 1, 2, 1);
    step("R3", 1, 15, 1, 2, 1);
    for (int i = 0; i < 4; i++) step("R3", 0, 15, 0, 0, 0);
    // R9: scratch byte and pin; writes change no output
    step("R9", 0, 15, 1, 3, 8'hA5);
    step("R9", 0, 15, 1, 4, 8'h00);
    for (int i = 0; i < 8; i++) step("R9", 0, 15, 0, 0, 0);
    step("R9", 0, 12, 1, 3, 8'h5A);
    for (int i = 0; i < 8; i++) step("R9", 0, 12, 0, 0, 0);
    // R10: writes to holes
    for (int a = 5; a < 8; a++) step("R10", 0, 10, 1, a, 8'hFF);
    for (int i = 0; i < 8; i++) step("R10", 0, 10, 0, 0, 0);
    sweep("R10");
    // R4: reset in mid-run with state loaded
    @(negedge clk);
    compare();
    rstN = 1'b0;
    #1;
    tag = "R4";
    for (int i = 0; i < 3; i++) step("R4", 0, 3, 0, 0, 0);
    rstN = 1'b1;
    for (int i = 0; i < 8; i++) step("R4", 0, 3, 0, 0, 0);
    sweep("R4");
    @(negedge clk);
    compare();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule